// File: doc/BRIEF.md
# MMU Fault Status and Interrupt Unit

This block sits beside an address translator and records the error events the translator reports. Eight fault causes arrive as single-cycle pulses together with the virtual address, the physical address and the requester identity (agent group and port) of the access that failed. Each cause sets a sticky status bit. The first fault after a clear also freezes a snapshot of the address and identity information, and any later fault only adds status bits. A single level-sensitive interrupt line is high while any recorded cause has its enable set.

Software reaches the block through a simple register port. Writes are single-cycle strobes and reads are combinational. An interrupt-control register holds the per-cause enables and a self-resetting clear bit. Writing that register with the clear bit set wipes the recorded state and drops the interrupt. A separate configuration register holds a two-bit protect-mode field and a coherent-access enable, and these are passed on to the translator.

Top module: `mmu_fault_irq_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A pulse on `evt_cause[i]` sets status bit i at the next clock edge, and the bit stays set until a clear. The cause bits are: 0 translation fault, 1 multi-hit, 2 invalid PA, 3 entry replacement, 4 table walk, 5 TLB miss, 6 prefetch DMA FIFO overflow, 7 miss DMA FIFO overflow. Several causes may pulse together.
- R3: `irq` equals the OR over i of (status bit i AND enable bit i). It follows a change in status or enables one clock edge after that change.
- R4: The first fault after reset or clear captures the fault VA (address bits 31:12 kept, bits 11:0 read zero), the fault PA and the fault ID. Later faults leave all three unchanged until the next clear.
- R5: The fault ID holds the port in bits 11:8 and (6 minus group) modulo 8 in bits 15:13. All other ID bits are zero.
- R6: A write to offset 1 loads the enables from bits 7:0. If bit 12 of that write is set, the write also zeroes status, VA, PA and ID, which drops `irq`. Bit 12 always reads back as zero. A write to offset 1 with bit 12 clear leaves the recorded fault state untouched.
- R7: A fault pulse in the same cycle as a clear write is recorded as a new first fault. Its status bits and information are kept.
- R8: The configuration register at offset 0 keeps bits 6:5 (protect mode, on `prot_mode`) and bit 8 (coherent enable, on `coherent_en`). Its other bits read zero, and it has no effect on `irq`.
- R9: Writes to the read-only offsets 2 (status), 3 (VA), 4 (PA) and 5 (ID) are ignored.
- R10: Offsets 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_cause | input | 8 | Fault cause pulses |
| evt_va | input | 32 | Virtual address of the faulting access |
| evt_pa | input | 32 | Physical address of the faulting access |
| evt_group | input | 3 | Agent group of the requester |
| evt_port | input | 4 | Port of the requester inside its group |
| prot_mode | output | 2 | Translation-fault protect mode |
| coherent_en | output | 1 | Coherent access enable |
| irq | output | 1 | Level-sensitive fault interrupt |

## Verification
The bench sweeps all 256 enable masks against a fixed multi-bit status and walks each cause on its own. It exercises every group and port value, which exposes a design that latches status through the enable, inverts the group index wrongly, or shifts the ID fields. It fires a second fault after the first to catch a snapshot that gets overwritten. It places a fault in the very cycle of a clear; a design that lets the clear win would lose that fault and show zero status. It also writes every read-only offset and reads back the clear bit. A design that decodes too widely, or keeps the clear bit as a stored bit, would show altered values there.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
    localparam int DATA_W       = 32;
    localparam int RADDR_W      = 3;
    localparam int CLR_BIT      = 12;
    localparam int PROT_LSB     = 5;
    localparam int PROT_W       = 2;
    localparam int COH_BIT      = 8;
    localparam int ID_PORT_LSB  = 8;
    localparam int ID_GROUP_LSB = 13;
    localparam int GROUP_TOP    = 6;

    typedef enum logic [RADDR_W-1:0] {
        OFS_CFG     = 3'd0,
        OFS_IRQ_CTL = 3'd1,
        OFS_STATUS  = 3'd2,
        OFS_VA      = 3'd3,
        OFS_PA      = 3'd4,
        OFS_ID      = 3'd5
    } reg_ofs_e;
endpackage

// File: rtl/mfu_ctrl_regs.sv
module mfu_ctrl_regs
    import mfu_pkg::*;
#(
    parameter int CAUSE_N = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [CAUSE_N-1:0]       enables,
    output logic [PROT_W-1:0]        prot_mode,
    output logic                     coherent_en,
    output logic                     clr_pulse
);
    typedef struct packed {
        logic [CAUSE_N-1:0] en;
        logic [PROT_W-1:0]  prot;
        logic               coh;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  hit_cfg, hit_ctl;

    always_comb begin
        hit_cfg = wr_en && (wr_addr == OFS_CFG);
        hit_ctl = wr_en && (wr_addr == OFS_IRQ_CTL);
        ctrl_d  = ctrl_q;
        if (hit_cfg) begin
            ctrl_d.prot = wdata[PROT_LSB +: PROT_W];
            ctrl_d.coh  = wdata[COH_BIT];
        end
        if (hit_ctl) begin
            ctrl_d.en = wdata[CAUSE_N-1:0];
        end
        clr_pulse = hit_ctl && wdata[CLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign enables     = ctrl_q.en;
    assign prot_mode   = ctrl_q.prot;
    assign coherent_en = ctrl_q.coh;
endmodule

// File: rtl/mfu_fault_capture.sv
module mfu_fault_capture
    import mfu_pkg::*;
#(
    parameter int CAUSE_N    = 8,
    parameter int PORT_W     = 4,
    parameter int GROUP_W    = 3,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [CAUSE_N-1:0]   evt,
    input  logic [DATA_W-1:0]    evt_va,
    input  logic [DATA_W-1:0]    evt_pa,
    input  logic [GROUP_W-1:0]   evt_group,
    input  logic [PORT_W-1:0]    evt_port,
    output logic [CAUSE_N-1:0]   status,
    output logic [DATA_W-1:0]    fault_va,
    output logic [DATA_W-1:0]    fault_pa,
    output logic [DATA_W-1:0]    fault_id
);
    localparam logic [DATA_W-1:0]  VA_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));
    localparam logic [GROUP_W-1:0] TOP_IDX = GROUP_W'(GROUP_TOP);

    typedef struct packed {
        logic [CAUSE_N-1:0] st;
        logic [DATA_W-1:0]  va;
        logic [DATA_W-1:0]  pa;
        logic [DATA_W-1:0]  id;
    } cap_t;

    cap_t cap_d, cap_q;
    logic open_win;
    logic [DATA_W-1:0] id_enc;

    always_comb begin
        id_enc = '0;
        id_enc[ID_GROUP_LSB +: GROUP_W] = TOP_IDX - evt_group;
        id_enc[ID_PORT_LSB  +: PORT_W]  = evt_port;

        cap_d    = cap_q;
        open_win = clr || (cap_q.st == '0);
        if (clr) begin
            cap_d = '0;
        end
        cap_d.st = cap_d.st | evt;
        if (open_win && (evt != '0)) begin
            cap_d.va = evt_va & VA_MASK;
            cap_d.pa = evt_pa;
            cap_d.id = id_enc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign status   = cap_q.st;
    assign fault_va = cap_q.va;
    assign fault_pa = cap_q.pa;
    assign fault_id = cap_q.id;
endmodule

// File: rtl/mfu_read_mux.sv
module mfu_read_mux
    import mfu_pkg::*;
#(
    parameter int CAUSE_N = 8
) (
    input  logic [RADDR_W-1:0]  addr,
    input  logic [CAUSE_N-1:0]  enables,
    input  logic [PROT_W-1:0]   prot_mode,
    input  logic                coherent_en,
    input  logic [CAUSE_N-1:0]  status,
    input  logic [DATA_W-1:0]   fault_va,
    input  logic [DATA_W-1:0]   fault_pa,
    input  logic [DATA_W-1:0]   fault_id,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CFG: begin
                rdata[PROT_LSB +: PROT_W] = prot_mode;
                rdata[COH_BIT]            = coherent_en;
            end
            OFS_IRQ_CTL: rdata[CAUSE_N-1:0] = enables;
            OFS_STATUS:  rdata[CAUSE_N-1:0] = status;
            OFS_VA:      rdata = fault_va;
            OFS_PA:      rdata = fault_pa;
            OFS_ID:      rdata = fault_id;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/mmu_fault_irq_unit.sv
module mmu_fault_irq_unit
    import mfu_pkg::*;
#(
    parameter int CAUSE_N    = 8,
    parameter int PORT_W     = 4,
    parameter int GROUP_W    = 3,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [7:0]          evt_cause,
    input  logic [31:0]         evt_va,
    input  logic [31:0]         evt_pa,
    input  logic [2:0]          evt_group,
    input  logic [3:0]          evt_port,
    output logic [1:0]          prot_mode,
    output logic                coherent_en,
    output logic                irq
);
    logic [CAUSE_N-1:0] enables;
    logic [CAUSE_N-1:0] status_q;
    logic [DATA_W-1:0]  fault_va, fault_pa, fault_id;
    logic               clr_pulse;

    mfu_ctrl_regs #(.CAUSE_N(CAUSE_N)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_addr     (reg_addr),
        .wdata       (reg_wdata),
        .enables     (enables),
        .prot_mode   (prot_mode),
        .coherent_en (coherent_en),
        .clr_pulse   (clr_pulse)
    );

    mfu_fault_capture #(
        .CAUSE_N    (CAUSE_N),
        .PORT_W     (PORT_W),
        .GROUP_W    (GROUP_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_pulse),
        .evt       (evt_cause),
        .evt_va    (evt_va),
        .evt_pa    (evt_pa),
        .evt_group (evt_group),
        .evt_port  (evt_port),
        .status    (status_q),
        .fault_va  (fault_va),
        .fault_pa  (fault_pa),
        .fault_id  (fault_id)
    );

    mfu_read_mux #(.CAUSE_N(CAUSE_N)) u_rd (
        .addr        (reg_addr),
        .enables     (enables),
        .prot_mode   (prot_mode),
        .coherent_en (coherent_en),
        .status      (status_q),
        .fault_va    (fault_va),
        .fault_pa    (fault_pa),
        .fault_id    (fault_id),
        .rdata       (reg_rdata)
    );

    assign irq = |(status_q & enables);
endmodule

// File: rtl/mfu_checker.sv
module mfu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic [7:0]  evt,
    input logic [7:0]  status,
    input logic [31:0] va,
    input logic [31:0] pa,
    input logic [31:0] id,
    input logic        irq
);
    // R3: the interrupt needs at least one recorded cause
    p_irq_needs_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 8'd0));

    // R2: without a clear, recorded bits never fall
    p_sticky_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status)));

    // R4: snapshot frozen once a fault is held
    p_first_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 8'd0 && !clr) |=> ($stable(va) && $stable(pa) && $stable(id)));

    // R4: page offset never stored
    p_va_offset_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        va[11:0] == 12'd0);

    // R5: unused ID bits stay zero
    p_id_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (id[7:0] == 8'd0) && (id[12] == 1'b0) && (id[31:16] == 16'd0));

    // R6: clear with no new fault empties the state
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == 8'd0) |=> (status == 8'd0 && !irq && va == 32'd0 && pa == 32'd0 && id == 32'd0));

    // R7: a fault in the clear cycle survives
    p_clear_keeps_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == $past(evt)));
endmodule

bind mmu_fault_irq_unit mfu_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_pulse),
    .evt    (evt_cause),
    .status (status_q),
    .va     (fault_va),
    .pa     (fault_pa),
    .id     (fault_id),
    .irq    (irq)
);

// File: tb/mmu_fault_irq_unit_tb.sv
module mmu_fault_irq_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_cause = 8'd0;
    logic [31:0] evt_va = 32'd0;
    logic [31:0] evt_pa = 32'd0;
    logic [2:0]  evt_group = 3'd0;
    logic [3:0]  evt_port = 4'd0;
    logic [1:0]  prot_mode;
    logic        coherent_en;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_fault_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_cause(evt_cause),
        .evt_va(evt_va), .evt_pa(evt_pa), .evt_group(evt_group),
        .evt_port(evt_port), .prot_mode(prot_mode), .coherent_en(coherent_en),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_id(input int g, input int p);
        return (((6 - g) & 7) << 13) | ((p & 15) << 8);
    endfunction

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // drives at negedge, returns at the following negedge
    task automatic cycle(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                         input logic [7:0] c, input logic [31:0] va, input logic [31:0] pa,
                         input logic [2:0] g, input logic [3:0] p);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        evt_cause = c; evt_va = va; evt_pa = pa; evt_group = g; evt_port = p;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; evt_cause = 8'd0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 8'd0, 32'd0, 32'd0, 3'd0, 4'd0);
    endtask

    task automatic fire(input logic [7:0] c, input logic [31:0] va, input logic [31:0] pa,
                        input logic [2:0] g, input logic [3:0] p);
        cycle(1'b0, 3'd0, 32'd0, c, va, pa, g, p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset register", d, 32'd0);
        end
        check("R1 reset irq", {31'd0, irq}, 32'd0);

        // R2/R3/R4 each cause alone
        for (int i = 0; i < 8; i++) begin
            logic [31:0] va = 32'h1000_0000 + (i * 32'h0001_1357) + 32'h0abc;
            logic [31:0] pa = 32'h8000_0000 + i * 32'h40;
            wr(3'd1, 32'h1000 | (32'd1 << i));
            fire(8'd1 << i, va, pa, 3'(i % 7), 4'(i + 3));
            rd(3'd2, d); check("R2 single cause status", d, 32'd1 << i);
            check("R3 enabled cause raises irq", {31'd0, irq}, 32'd1);
            rd(3'd3, d); check("R4 fault VA page bits", d, va & 32'hffff_f000);
            rd(3'd4, d); check("R4 fault PA", d, pa);
            rd(3'd5, d); check("R5 fault ID", d, exp_id(i % 7, i + 3));
            wr(3'd1, 32'h0000_00ff & ~(32'd1 << i));
            check("R3 other enables keep irq low", {31'd0, irq}, 32'd0);
            rd(3'd2, d); check("R6 enable write without clear keeps status", d, 32'd1 << i);
        end

        // R3 exhaustive enable sweep against a fixed status
        wr(3'd1, 32'h1000);
        fire(8'hA5, 32'h0000_5000, 32'h0, 3'd0, 4'd0);
        for (int m = 0; m < 256; m++) begin
            wr(3'd1, 32'(m));
            check("R3 irq equals OR of status and enable", {31'd0, irq}, {31'd0, |(8'hA5 & 8'(m))});
            rd(3'd1, d); check("R6 enable readback", d, 32'(m));
        end

        // R5 all groups and ports
        for (int g = 0; g < 8; g++) begin
            for (int p = 0; p < 16; p++) begin
                wr(3'd1, 32'h1000);
                fire(8'h02, 32'h0, 32'h0, 3'(g), 4'(p));
                rd(3'd5, d); check("R5 ID encoding sweep", d, exp_id(g, p));
            end
        end

        // R4 first fault wins, later faults only add status
        wr(3'd1, 32'h10ff);
        fire(8'h01, 32'hAAAA_A123, 32'h1111_0000, 3'd2, 4'd5);
        fire(8'h10, 32'hBBBB_B456, 32'h2222_0000, 3'd4, 4'd9);
        rd(3'd2, d); check("R2 status accumulates", d, 32'h11);
        rd(3'd3, d); check("R4 VA kept from first fault", d, 32'hAAAA_A000);
        rd(3'd4, d); check("R4 PA kept from first fault", d, 32'h1111_0000);
        rd(3'd5, d); check("R4 ID kept from first fault", d, exp_id(2, 5));

        // R6 clear
        wr(3'd1, 32'h10ff);
        rd(3'd2, d); check("R6 clear zeroes status", d, 32'd0);
        rd(3'd3, d); check("R6 clear zeroes VA", d, 32'd0);
        rd(3'd4, d); check("R6 clear zeroes PA", d, 32'd0);
        rd(3'd5, d); check("R6 clear zeroes ID", d, 32'd0);
        check("R6 clear drops irq", {31'd0, irq}, 32'd0);
        rd(3'd1, d); check("R6 clear bit reads zero", d, 32'h0000_00ff);

        // R7 fault in the clear cycle
        fire(8'h04, 32'hCCCC_C000, 32'h3333_0000, 3'd1, 4'd1);
        cycle(1'b1, 3'd1, 32'h10ff, 8'h40, 32'hDDDD_D789, 32'h4444_0000, 3'd3, 4'd7);
        rd(3'd2, d); check("R7 status from clear-cycle fault", d, 32'h40);
        rd(3'd3, d); check("R7 VA from clear-cycle fault", d, 32'hDDDD_D000);
        rd(3'd4, d); check("R7 PA from clear-cycle fault", d, 32'h4444_0000);
        rd(3'd5, d); check("R7 ID from clear-cycle fault", d, exp_id(3, 7));
        check("R7 irq for clear-cycle fault", {31'd0, irq}, 32'd1);

        // R9 read-only offsets ignore writes
        for (int a = 2; a < 6; a++) wr(3'(a), 32'hFFFF_FFFF);
        rd(3'd2, d); check("R9 status write ignored", d, 32'h40);
        rd(3'd3, d); check("R9 VA write ignored", d, 32'hDDDD_D000);
        rd(3'd4, d); check("R9 PA write ignored", d, 32'h4444_0000);
        rd(3'd5, d); check("R9 ID write ignored", d, exp_id(3, 7));
        rd(3'd1, d); check("R9 enables untouched", d, 32'h0000_00ff);

        // R8 configuration register
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R8 cfg keeps only its fields", d, 32'h0000_0160);
        check("R8 prot_mode output", {30'd0, prot_mode}, 32'd3);
        check("R8 coherent output", {31'd0, coherent_en}, 32'd1);
        check("R8 cfg leaves irq", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h0000_0040);
        rd(3'd0, d); check("R8 protect mode value 2", d, 32'h0000_0040);
        check("R8 coherent off", {31'd0, coherent_en}, 32'd0);
        rd(3'd2, d); check("R8 cfg write leaves status", d, 32'h40);

        // R10 unmapped offsets
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, d); check("R10 offset 6 reads zero", d, 32'd0);
        rd(3'd7, d); check("R10 offset 7 reads zero", d, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule